// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter

This block is a binary up-counter assembled from identical 4-bit slices. Each slice can be cleared, preset from a parallel value, held or advanced by one. Every change takes place on the rising clock edge. A slice advances only when both of its enables are high. The first enable, the parallel enable, goes to every slice at once. The second, the chained enable, reaches the lowest slice from the port. Every higher slice takes it from the carry of the slice below.

Each slice raises a combinational carry when its chained enable is high and its count is all ones. That carry lets the next slice up take one step on the same edge, so all slices share one clock and the total width is the slice count times four. A single slice that runs freely divides the clock by sixteen. The whole counter wraps from all ones to zero. The count holds no defined value until the first clear has been applied.

Top module: `casc_counter`

## Requirements
- R1: With `clear_i` high at a rising edge, the whole count becomes zero, whatever `load_i`, `load_val_i` and the enables hold.
- R2: With `load_i` high and `clear_i` low at a rising edge, the count takes the value of `load_val_i`, whatever the enables hold.
- R3: With clear and load both low, the count holds its value across an edge unless `enp_i` and `ent_i` are both high.
- R4: `carry_o` is high exactly when `ent_i` is high and every count bit is 1. It follows `ent_i` within the same cycle, and `enp_i` has no effect on it.
- R5: With clear and load low and both enables high, the count rises by one per edge, and all ones wraps to zero.
- R6: A slice above bit 3 steps only on an edge where every lower slice reads 15 and the count is enabled. For example, 8'h0F steps to 8'h10.
- R7: In free running, each 4-bit slice passes through all 16 values in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clear_i | input | 1 | Synchronous clear; highest priority |
| load_i | input | 1 | Synchronous parallel preset; second priority |
| load_val_i | input | 4*NUM_SLICES | Value copied in on a preset |
| enp_i | input | 1 | Parallel enable, shared by every slice |
| ent_i | input | 1 | Chained enable into the lowest slice; also gates the carry |
| count_o | output | 4*NUM_SLICES | Current count |
| carry_o | output | 1 | High when `ent_i` is high and the count is all ones |

## Verification
Two corner cases are the hardest to reach from the ports: a carry into an upper slice, and the wrap of the whole counter. Both appear only after many counting edges from zero. The stimulus reaches them quickly with the preset, loading values such as 8'h0E and 8'hFE one or two steps below each boundary. At all ones it toggles each enable by itself, showing that the carry follows only the chained enable. A closing free run of 256 edges then covers every transition of both slices.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
    localparam int SLICE_W = 4;
    typedef logic [SLICE_W-1:0] nibble_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_PRESET = 2'd2,
        OP_ZERO  = 2'd3
    } slice_op_e;

    function automatic slice_op_e pick_op(input logic clr, input logic ld,
                                          input logic ep, input logic et);
        if (clr)          return OP_ZERO;
        else if (ld)      return OP_PRESET;
        else if (ep && et) return OP_STEP;
        else              return OP_HOLD;
    endfunction
endpackage

// File: rtl/ctr_next_logic.sv
module ctr_next_logic
    import ctr_pkg::*;
(
    input  slice_op_e op,
    input  nibble_t   cur,
    input  nibble_t   preset,
    output nibble_t   nxt
);
    always_comb begin
        unique case (op)
            OP_ZERO:   nxt = '0;
            OP_PRESET: nxt = preset;
            OP_STEP:   nxt = cur + 1'b1;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
    import ctr_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    ld,
    input  nibble_t preset,
    input  logic    ep,
    input  logic    et,
    output nibble_t q,
    output logic    tc
);
    slice_op_e op;
    nibble_t   q_r;
    nibble_t   q_nxt;

    assign op = pick_op(clr, ld, ep, et);

    ctr_next_logic u_next (
        .op     (op),
        .cur    (q_r),
        .preset (preset),
        .nxt    (q_nxt)
    );

    always_ff @(posedge clk) begin
        q_r <= q_nxt;
    end

    assign q  = q_r;
    assign tc = et & (&q_r);
endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import ctr_pkg::*;
#(
    parameter int NUM_SLICES = 3,
    localparam int W = SLICE_W * NUM_SLICES
) (
    input  logic         clk,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         enp_i,
    input  logic         ent_i,
    output logic [W-1:0] count_o,
    output logic         carry_o
);
    logic [NUM_SLICES:0] chain;

    assign chain[0] = ent_i;

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        nibble_t q_k;
        ctr_slice u_slice (
            .clk    (clk),
            .clr    (clear_i),
            .ld     (load_i),
            .preset (load_val_i[k*SLICE_W +: SLICE_W]),
            .ep     (enp_i),
            .et     (chain[k]),
            .q      (q_k),
            .tc     (chain[k+1])
        );
        assign count_o[k*SLICE_W +: SLICE_W] = q_k;
    end

    assign carry_o = chain[NUM_SLICES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         clear_i,
    input logic         load_i,
    input logic [W-1:0] load_val_i,
    input logic         enp_i,
    input logic         ent_i,
    input logic [W-1:0] count_o,
    input logic         carry_o
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (clear_i) armed <= 1'b1;
    end

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
        clear_i |=> (count_o == '0));

    assert_preset_copy_R2: assert property (@(posedge clk) disable iff (!armed)
        (!clear_i && load_i) |=> (count_o == $past(load_val_i)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!armed)
        (!clear_i && !load_i && !(enp_i && ent_i)) |=> $stable(count_o));

    assert_carry_R4: assert property (@(posedge clk) disable iff (!armed)
        carry_o == (ent_i && (count_o == {W{1'b1}})));

    assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!armed)
        (!clear_i && !load_i && enp_i && ent_i) |=> (count_o == $past(count_o) + 1'b1));
endmodule

bind casc_counter casc_counter_chk #(.W(W)) u_chk (
    .clk        (clk),
    .clear_i    (clear_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .enp_i      (enp_i),
    .ent_i      (ent_i),
    .count_o    (count_o),
    .carry_o    (carry_o)
);

// File: tb/sim_casc_counter.sv
`timescale 1ns/1ps
module sim_casc_counter;
    localparam int NS = 2;
    localparam int W  = 4 * NS;
    localparam int NV = 13;

    // {clear, load, value, enp, ent, expected count, expected carry}
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b1, 8'hAA, 1'b1, 1'b1, 8'h00, 1'b0}, // R1 clear beats load
        {1'b0, 1'b1, 8'h0E, 1'b1, 1'b1, 8'h0E, 1'b0}, // R2 load beats count
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h0F, 1'b0}, // R5 step
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h10, 1'b0}, // R6 ripple into upper slice
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'h10, 1'b0}, // R3 enp low holds
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'h10, 1'b0}, // R3 ent low holds
        {1'b0, 1'b1, 8'hFE, 1'b0, 1'b0, 8'hFE, 1'b0}, // R2 load with enables low
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'hFF, 1'b1}, // R4 carry at all ones
        {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b1}, // R4 carry ignores enp
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b0}, // R4 carry needs ent
        {1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0}, // R5 wrap to zero
        {1'b0, 1'b1, 8'h55, 1'b1, 1'b1, 8'h55, 1'b0}, // R2 load over count
        {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0}  // R1 clear over count
    };

    logic         clk = 1'b0;
    logic         clear_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] load_val_i = '0;
    logic         enp_i = 1'b0;
    logic         ent_i = 1'b0;
    logic [W-1:0] count_o;
    logic         carry_o;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    casc_counter #(.NUM_SLICES(NS)) u0 (
        .clk(clk), .clear_i(clear_i), .load_i(load_i), .load_val_i(load_val_i),
        .enp_i(enp_i), .ent_i(ent_i), .count_o(count_o), .carry_o(carry_o)
    );

    task automatic check(input string req, input logic [W-1:0] exp_c, input logic exp_k);
        total++;
        if (count_o !== exp_c || carry_o !== exp_k) begin
            bad++;
            $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
                     req, count_o, carry_o, exp_c, exp_k);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] model;
        // reset state: first clear defines the count (R1)
        @(negedge clk);
        clear_i = 1'b1; ent_i = 1'b0; enp_i = 1'b0;
        step();
        check("R1 initial clear", 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {clear_i, load_i, load_val_i, enp_i, ent_i} = VEC[i][20:9];
            step();
            check($sformatf("vector %0d", i), VEC[i][8:1], VEC[i][0]);
        end

        // R4: carry follows ent mid-cycle with no clock edge involved
        @(negedge clk);
        clear_i = 1'b0; load_i = 1'b1; load_val_i = 8'hFF; enp_i = 1'b0; ent_i = 1'b0;
        step();
        load_i = 1'b0;
        #0.2;
        check("R4 ent low at all ones", 8'hFF, 1'b0);
        ent_i = 1'b1;
        #0.2;
        check("R4 same-cycle carry rise", 8'hFF, 1'b1);
        ent_i = 1'b0;
        #0.2;
        check("R4 same-cycle carry fall", 8'hFF, 1'b0);

        // R5 R6 R7: free run over the full range from zero
        @(negedge clk);
        clear_i = 1'b1;
        step();
        check("R1 clear before free run", 8'h00, 1'b0);
        @(negedge clk);
        clear_i = 1'b0; enp_i = 1'b1; ent_i = 1'b1;
        model = '0;
        for (int n = 0; n < 256; n++) begin
            step();
            model = model + 1'b1;
            check("R7 free run", model, (model == 8'hFF));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule